// File: doc/BRIEF.md
# Asynchronous ROM/RAM Combo Memory Controller

This block turns single-beat commands from a clocked request port into pin sequences for an external asynchronous memory. That memory holds a read-only region and a read/write static region. The two regions share one 8-bit data bus, one write strobe and one output strobe. Each region has its own active-low select. Every phase of a pin sequence lasts a number of clock cycles. That number is worked out at elaboration from the clock period and the memory's minimum timings, so changing the clock only needs a new parameter value.

A command is taken when `cmd_valid` and `cmd_ready` are both high at a rising clock edge. A read drives the address, lowers the region select and the output strobe together, and waits out the access time. It then stores the bus value and returns it with a one-cycle `rsp_valid` pulse. A write to the RAM region lowers the RAM select and the write strobe on the same edge, drives the data for the whole strobe, and raises both together. It then holds the data during a tail that fills out the write cycle, and answers with `rsp_valid`. A write aimed at the ROM region touches no pin and answers at once with `rsp_err` set. Every access is followed by a turnaround gap in which both selects and both strobes stay high.

The control is one state machine with six states:
- IDLE waits for a command.
- RD_ACC holds a read.
- WR_PULSE holds the write strobe.
- WR_TAIL completes the write cycle.
- DONE gives the response pulse.
- GAP is the turnaround.

Its transitions are:
- IDLE to RD_ACC on an accepted read.
- IDLE to WR_PULSE on an accepted RAM write.
- IDLE to DONE on a rejected ROM write.
- RD_ACC to DONE when the access count expires, storing the read data.
- WR_PULSE to WR_TAIL when the pulse count expires.
- WR_TAIL to DONE when the tail count expires.
- DONE to GAP always.
- GAP to IDLE when the turnaround count expires.

Top module: `amc_ctrl`

## Requirements
- R1: During and right after reset, both selects, the write strobe and the output strobe are high, `mem_dq_oe` is 0, `rsp_valid` and `rsp_err` are 0, and `cmd_ready` is 1.
- R2: The ROM select and the RAM select are never low in the same cycle, including across back-to-back accesses to different regions.
- R3: A ROM read (`cmd_rom`=1, `cmd_we`=0) places the 18-bit address on `mem_addr` and lowers the ROM select and output strobe. Read data is stored no earlier than ceil(500 ns / clock period) cycles after they fall, and it is returned on `rsp_rdata`.
- R4: A RAM access (`cmd_rom`=0) uses only address bits 14..0. Address bits 17..15 on `mem_addr` are 0 while the RAM select is low, and a RAM read returns the byte most recently written to that 15-bit address.
- R5: A RAM write lowers the RAM select and the write strobe on the same edge and raises them on the same edge. The output strobe stays high throughout, and the strobe stays low for at least ceil(375 ns / clock period) cycles.
- R6: The write data is driven (`mem_dq_oe`=1) and held unchanged for every cycle of the write strobe. The data driver is never on while the output strobe is low.
- R7: The response to an accepted read or RAM write comes no earlier than ceil(500 ns / clock period) cycles after acceptance.
- R8: Between the end of one access and the start of the next, both selects stay high for at least 1 + ceil(80 ns / clock period) cycles.
- R9: A write with `cmd_rom`=1 produces no select or write-strobe activity. It is answered with `rsp_valid`=1 and `rsp_err`=1 in the same cycle.
- R10: Each accepted command gets exactly one `rsp_valid` pulse of one cycle. `rsp_err` is 0 for reads and RAM writes.
- R11: `cmd_valid` while `cmd_ready` is 0 is ignored: it produces no response and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command this cycle |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_rom | input | 1 | 1 = ROM region, 0 = RAM region |
| cmd_addr | input | 18 | Byte address; only bits 14..0 are used for the RAM region |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a rejected ROM write |
| rsp_rdata | output | 8 | Read data, valid with the response to a read |
| mem_addr | output | 18 | Memory address pins |
| mem_rom_cs_n | output | 1 | ROM region select, active low |
| mem_ram_cs_n | output | 1 | RAM region select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | 8 | Data read from the memory bus |

## Verification
A wrong state or a count that runs short shows up in the pins at once. Two selects low together, a write strobe without the RAM select, or a driver on under a low output strobe are all visible in the cycle they occur. A count that expires early is caught by a bench memory model that returns wrong data until the full access time has passed. In that case the stored read byte is wrong at the next response. A pulse that is too short, or a gap that is too short, is measured and reported when the strobe or select next rises or falls. A missed or extra response is found when the command's result is compared, or by the response count after an ignored command.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_PULSE,
        ST_WR_TAIL,
        ST_DONE,
        ST_GAP
    } amc_state_e;

    // ceiling of a / b for positive integers
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/amc_timer.sv
module amc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/amc_datapath.sv
module amc_datapath #(
    parameter int ROM_AW = 18,
    parameter int RAM_AW = 15,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic              lat_rom,
    input  logic [ROM_AW-1:0] lat_addr,
    input  logic [DW-1:0]     lat_wdata,
    input  logic              cap,
    input  logic [DW-1:0]     mem_dq_i,
    output logic [ROM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_dq_o,
    output logic [DW-1:0]     rsp_rdata
);
    logic [ROM_AW-1:0] ram_addr;

    // RAM accesses keep the unused high address pins at a fixed low level
    generate
        if (ROM_AW > RAM_AW) begin : g_pad
            assign ram_addr = {{(ROM_AW - RAM_AW){1'b0}}, lat_addr[RAM_AW-1:0]};
        end else begin : g_nopad
            assign ram_addr = lat_addr;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (latch) begin
            mem_addr <= lat_rom ? lat_addr : ram_addr;
            mem_dq_o <= lat_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (cap) begin
            rsp_rdata <= mem_dq_i;
        end
    end
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
    import amc_pkg::*;
#(
    parameter int CLK_NS     = 8,
    parameter int ROM_AW     = 18,
    parameter int RAM_AW     = 15,
    parameter int DW         = 8,
    parameter int T_RC_NS    = 500,
    parameter int T_AA_NS    = 500,
    parameter int T_OE_NS    = 250,
    parameter int T_WC_NS    = 500,
    parameter int T_WP_NS    = 375,
    parameter int T_CW_NS    = 365,
    parameter int T_AW_NS    = 375,
    parameter int T_DW_NS    = 200,
    parameter int T_TURN_NS  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_we,
    input  logic              cmd_rom,
    input  logic [ROM_AW-1:0] cmd_addr,
    input  logic [DW-1:0]     cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [ROM_AW-1:0] mem_addr,
    output logic              mem_rom_cs_n,
    output logic              mem_ram_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DW-1:0]     mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_i
);
    // phase lengths in clock cycles
    localparam int N_RD   = imax(cdiv(imax(T_AA_NS, T_RC_NS), CLK_NS), cdiv(T_OE_NS, CLK_NS));
    localparam int N_WP   = cdiv(imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS)), CLK_NS);
    localparam int N_WT   = imax(1, cdiv(T_WC_NS, CLK_NS) - N_WP);
    localparam int N_GAP  = imax(1, cdiv(T_TURN_NS, CLK_NS));
    localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(N_WT, N_GAP));
    localparam int CNT_W  = $clog2(N_MAX + 1);
    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] LD_WT  = CNT_W'(N_WT - 1);
    localparam logic [CNT_W-1:0] LD_GAP = CNT_W'(N_GAP - 1);

    amc_state_e       state_q, state_d;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic             accept;
    logic             op_rom_q, op_rej_q;
    logic             op_rom_d, op_rej_d;
    logic             cap;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign op_rom_d = accept ? cmd_rom : op_rom_q;
    assign op_rej_d = accept ? (cmd_we && cmd_rom) : op_rej_q;
    assign cap      = (state_q == ST_RD_ACC) && t_zero;

    amc_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    amc_datapath #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch     (accept),
        .lat_rom   (cmd_rom),
        .lat_addr  (cmd_addr),
        .lat_wdata (cmd_wdata),
        .cap       (cap),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rsp_rdata (rsp_rdata)
    );

    // next state and phase counter loads
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_we && cmd_rom) begin
                        state_d = ST_DONE;
                    end else if (cmd_we) begin
                        state_d = ST_WR_PULSE;
                        t_load  = 1'b1;
                        t_val   = LD_WP;
                    end else begin
                        state_d = ST_RD_ACC;
                        t_load  = 1'b1;
                        t_val   = LD_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (t_zero) state_d = ST_DONE;
            end
            ST_WR_PULSE: begin
                if (t_zero) begin
                    state_d = ST_WR_TAIL;
                    t_load  = 1'b1;
                    t_val   = LD_WT;
                end
            end
            ST_WR_TAIL: begin
                if (t_zero) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_GAP;
                t_load  = 1'b1;
                t_val   = LD_GAP;
            end
            ST_GAP: begin
                if (t_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_rom_q <= 1'b0;
            op_rej_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            op_rom_q <= op_rom_d;
            op_rej_q <= op_rej_d;
        end
    end

    // registered outputs decoded from the next state, so pins change glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rom_cs_n <= 1'b1;
            mem_ram_cs_n <= 1'b1;
            mem_we_n     <= 1'b1;
            mem_oe_n     <= 1'b1;
            mem_dq_oe    <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            cmd_ready    <= 1'b1;
        end else begin
            mem_rom_cs_n <= !((state_d == ST_RD_ACC) && op_rom_d);
            mem_ram_cs_n <= !(((state_d == ST_RD_ACC) && !op_rom_d) || (state_d == ST_WR_PULSE));
            mem_we_n     <= !(state_d == ST_WR_PULSE);
            mem_oe_n     <= !(state_d == ST_RD_ACC);
            mem_dq_oe    <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_TAIL);
            rsp_valid    <= (state_d == ST_DONE);
            rsp_err      <= (state_d == ST_DONE) && op_rej_d;
            cmd_ready    <= (state_d == ST_IDLE);
        end
    end

    // R2
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rom_cs_n || mem_ram_cs_n);

    // R5
    we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ram_cs_n && mem_rom_cs_n));

    // R5
    we_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ram_cs_n));

    // R6
    drv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    drv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_o));

    // R4
    ram_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ram_cs_n |-> (mem_addr[ROM_AW-1:RAM_AW] == '0));

    // R8
    gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rom_cs_n) || $rose(mem_ram_cs_n)) |=> (mem_rom_cs_n && mem_ram_cs_n));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && mem_we_n && mem_rom_cs_n && mem_ram_cs_n));

endmodule

// File: tb/tb_amc_ctrl.sv
module tb_amc_ctrl;
    localparam int P     = 8;
    localparam int B_RD  = (500 + P - 1) / P;
    localparam int B_WP  = (375 + P - 1) / P;
    localparam int B_WC  = (500 + P - 1) / P;
    localparam int B_GAP = 1 + (80 + P - 1) / P;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_we = 1'b0;
    logic        cmd_rom = 1'b0;
    logic [17:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_rom_cs_n, mem_ram_cs_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i = 8'h00;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(P / 2) clk = ~clk;

    amc_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_rom(cmd_rom),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_rom_cs_n(mem_rom_cs_n), .mem_ram_cs_n(mem_ram_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
    endfunction

    // memory model state (pin side) and expected RAM contents (command side)
    logic [7:0] ram_m   [int];
    logic [7:0] exp_ram [int];

    int          acc_n = 0;
    logic [17:0] acc_addr = '0;
    bit          prev_wr = 0;
    int          wr_len = 0;
    bit          wr_bad = 0;
    logic [7:0]  wr_data = '0;
    logic [14:0] wr_addr = '0;
    int          gap_run = 1000;
    bit          prev_high = 1;
    int          sel_falls = 0;
    int          we_falls = 0;
    int          rsp_cnt = 0;
    int          excl_viol = 0;
    int          cont_viol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            chk(0, "watchdog", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // pin monitor and memory model, evaluated away from the active edge
    always @(negedge clk) begin
        bit reading, in_wr, all_high;
        reading  = !mem_oe_n && (!mem_rom_cs_n || !mem_ram_cs_n);
        in_wr    = !mem_we_n && !mem_ram_cs_n;
        all_high = mem_rom_cs_n && mem_ram_cs_n;
        if (rst_n) begin
            if (!mem_rom_cs_n && !mem_ram_cs_n) excl_viol++;
            if (mem_dq_oe && !mem_oe_n) cont_viol++;
            if (rsp_valid) rsp_cnt++;
            // read access time model: wrong data until the full access time
            if (reading && acc_n > 0 && mem_addr == acc_addr) acc_n++;
            else acc_n = reading ? 1 : 0;
            acc_addr = mem_addr;
            if (reading) begin
                logic [7:0] v;
                v = !mem_rom_cs_n ? rom_byte(mem_addr)
                  : (ram_m.exists(int'(mem_addr[14:0])) ? ram_m[int'(mem_addr[14:0])] : 8'h00);
                mem_dq_i = (acc_n >= B_RD) ? v : ~v;
            end else begin
                mem_dq_i = 8'hE7;
            end
            // write window
            if (in_wr) begin
                if (!prev_wr) begin
                    we_falls++;
                    wr_len = 0;
                    wr_bad = 0;
                    wr_data = mem_dq_o;
                end
                wr_len++;
                if (!mem_dq_oe || !mem_oe_n || mem_dq_o != wr_data) wr_bad = 1;
                wr_addr = mem_addr[14:0];
            end else if (!mem_we_n) begin
                we_falls++;
                wr_bad = 1;
            end
            if (prev_wr && !in_wr) begin
                // R5 R6: pulse length and held data
                chk(wr_len >= B_WP && !wr_bad && mem_we_n && mem_ram_cs_n,
                    "R5/R6 write pulse", wr_len, B_WP);
                ram_m[int'(wr_addr)] = wr_data;
            end
            prev_wr = in_wr;
            // turnaround gap
            if (all_high) begin
                gap_run++;
            end else if (prev_high) begin
                sel_falls++;
                chk(gap_run >= B_GAP, "R8 gap", gap_run, B_GAP);
                gap_run = 0;
            end
            prev_high = all_high;
        end
    end

    // issue one command; optionally inject a second command while busy (R11)
    task automatic do_op(input bit we, input bit rom, input logic [17:0] addr,
                         input logic [7:0] wd, input bit inject);
        int t, acc_cyc, lat, rsp_before, wf_before, sf_before;
        logic [7:0] expv;
        t = 0;
        @(negedge clk);
        while (!cmd_ready && t < 2000) begin
            @(negedge clk);
            t++;
        end
        rsp_before = rsp_cnt;
        wf_before  = we_falls;
        sf_before  = sel_falls;
        cmd_valid = 1'b1; cmd_we = we; cmd_rom = rom; cmd_addr = addr; cmd_wdata = wd;
        acc_cyc = cyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            // R11: offered while cmd_ready is low
            chk(cmd_ready == 1'b0, "R11 busy", cmd_ready, 0);
            cmd_valid = 1'b1; cmd_we = 1'b1; cmd_rom = 1'b0;
            cmd_addr = 18'h00055; cmd_wdata = 8'hC3;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        t = 0;
        while (!rsp_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        lat = cyc - acc_cyc;
        if (we && rom) begin
            chk(rsp_valid && rsp_err, "R9 reject err", rsp_err, 1);
            chk(we_falls == wf_before && sel_falls == sf_before, "R9 no pins",
                we_falls - wf_before, 0);
        end else begin
            chk(rsp_valid && !rsp_err, "R10 err low", rsp_err, 0);
            chk(lat >= (we ? B_WC : B_RD), "R7 latency", lat, we ? B_WC : B_RD);
            if (we) begin
                exp_ram[int'(addr[14:0])] = wd;
            end else begin
                expv = rom ? rom_byte(addr)
                     : (exp_ram.exists(int'(addr[14:0])) ? exp_ram[int'(addr[14:0])] : 8'h00);
                chk(rsp_rdata == expv, rom ? "R3 rom data" : "R4 ram data", rsp_rdata, expv);
            end
        end
        @(negedge clk);
        // R10: single-cycle pulse, one per command
        chk(!rsp_valid && rsp_cnt == rsp_before + 1, "R10 pulse", rsp_cnt - rsp_before, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(mem_rom_cs_n && mem_ram_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe
            && !rsp_valid && !rsp_err && cmd_ready, "R1 reset", 0, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_rom_cs_n && mem_ram_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe
            && !rsp_valid && cmd_ready, "R1 after reset", 0, 1);

        // directed corners
        do_op(1, 0, 18'h00000, 8'h11, 0);
        do_op(1, 0, 18'h07FFF, 8'hEE, 0);
        do_op(0, 0, 18'h00000, 8'h00, 0);
        do_op(0, 0, 18'h3FFFF, 8'h00, 0);   // R4 upper bits dropped, reads 0x7FFF
        do_op(0, 1, 18'h00000, 8'h00, 0);   // R3
        do_op(0, 1, 18'h3FFFF, 8'h00, 0);   // R3
        do_op(1, 1, 18'h00123, 8'h99, 0);   // R9
        do_op(0, 1, 18'h00123, 8'h00, 0);   // R9 ROM content unchanged
        do_op(0, 0, 18'h00123, 8'h00, 0);   // R9 RAM not written
        do_op(0, 1, 18'h2A5A5, 8'h00, 0);   // R2 region switch back to back
        do_op(0, 0, 18'h025A5, 8'h00, 0);
        do_op(1, 0, 18'h01234, 8'h5A, 0);
        do_op(0, 1, 18'h01234, 8'h00, 0);
        do_op(0, 0, 18'h00055, 8'h00, 1);   // R11 inject write while busy
        repeat (200) @(negedge clk);
        do_op(0, 0, 18'h00055, 8'h00, 0);   // R11 must still read 0

        // constrained random mix
        for (int i = 0; i < 120; i++) begin
            logic [17:0] a;
            bit w, r;
            int pick;
            pick = int'($urandom_range(0, 9));
            r = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 1) == 1);
            if (r && w && $urandom_range(0, 3) != 0) r = 0;
            a = r ? 18'($urandom()) : {3'($urandom()), 7'h00, 5'($urandom_range(0, 7)), 3'($urandom())};
            if (pick == 0) a = 18'h3FFFF;
            do_op(w, r, a, 8'($urandom()), 0);
        end

        repeat (20) @(negedge clk);
        chk(excl_viol == 0, "R2 select exclusion", excl_viol, 0);
        chk(cont_viol == 0, "R6 no contention", cont_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule